// File: doc/BRIEF.md
# Checked Data Memory Port with Deferred Stores

This block guards a data memory built from 256-bit words. Every request is either wide, moving a whole word, or narrow, moving one 32-bit lane of a word. Before a request may touch the memory, its byte address is checked for alignment and range. A request that fails either check is reported as a bad-address fault: a faulting load returns zero and a faulting store is thrown away.

Stores that pass the checks do not write the memory at once. They wait in a small pending buffer until a commit strobe applies them, in the order they were issued, or an abort strobe discards them. Loads always read the committed memory contents. A fault stays latched until abort, so that the controlling sequencer can roll back the whole step. The memory array is held inside the block and clears to zero on reset.

Top module: `dmc_access_checker`

## Requirements
- R1: A wide request (req_wide=1) whose byte address is not a multiple of 32 is a fault.
- R2: A wide request whose word index, address divided by 32, is equal to or greater than MEM_WORDS (default 8) is a fault.
- R3: A narrow request (req_wide=0) whose byte address is not a multiple of 4 is a fault.
- R4: A narrow request is a fault when (address + 3) divided by 32 is equal to or greater than MEM_WORDS.
- R5: On a fault, rsp_fault is 1 and rsp_rdata is zero, and a faulting store is not added to the pending buffer (pend_cnt does not change).
- R6: A narrow request uses word address/32 and lane (address/4) mod 8, the lane taking bits [32*lane+31:32*lane] of the word; a narrow load returns that lane zero-extended in rsp_rdata[31:0], and a narrow store changes that lane only, taking its data from req_wdata[31:0].
- R7: A valid store is held pending and is not visible to loads until txn_commit; commit applies all pending stores in issue order, so a later store to the same place wins, and the memory changes at the clock edge that samples txn_commit.
- R8: txn_abort discards all pending stores and clears fault_pending; it has priority over txn_commit in the same cycle.
- R9: fault_pending rises the cycle after a faulting request and stays 1 until txn_abort; asserting txn_commit while fault_pending is 1 is forbidden.
- R10: The pending buffer holds PEND_DEPTH (default 2) stores; pend_cnt shows how many are held, and issuing a store while the buffer is full without a same-cycle commit or abort is forbidden.
- R11: After reset all outputs are zero and every memory word reads as zero.
- R12: Each request cycle (req_valid=1) produces exactly one rsp_valid pulse, one clock later; loads and stores both respond.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 for store, 0 for load |
| req_wide | input | 1 | 1 for a 256-bit access, 0 for a 32-bit lane |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 256 | Store data; narrow stores use bits [31:0] |
| txn_commit | input | 1 | Apply all pending stores to memory |
| txn_abort | input | 1 | Drop pending stores and clear the latched fault |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_fault | output | 1 | That request broke an alignment or range rule |
| rsp_rdata | output | 256 | Load data, zero for stores and faults |
| fault_pending | output | 1 | A fault has occurred since the last abort |
| pend_cnt | output | $clog2(PEND_DEPTH+1) | Number of stores waiting for commit |

## Verification
A wrong pending-buffer count or entry stays hidden until a commit, after which the next load of the affected address returns the wrong word or lane. For this reason every store sequence in the bench is followed by reads of each lane it touched. A lost or stuck fault flag shows on fault_pending one clock after the request or the abort. A wrong address decode shows on rsp_fault and rsp_rdata in the very next cycle. The reference model is compared with all outputs on every clock, so a divergence is reported at the first cycle where it becomes visible.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int WORD_W      = 256;
    localparam int LANE_W      = 32;
    localparam int LANES       = WORD_W / LANE_W;
    localparam int LANE_IDX_W  = $clog2(LANES);
    localparam int WORD_BYTE_W = $clog2(WORD_W / 8);
    localparam int LANE_BYTE_W = $clog2(LANE_W / 8);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANE_W-1:0] lane_t;

    // registered response and sticky fault of the top level
    typedef struct packed {
        logic  rsp_valid;
        logic  rsp_fault;
        word_t rdata;
        logic  fault;
    } port_state_t;
endpackage

// File: rtl/dmc_addr_check.sv
module dmc_addr_check
    import dmc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MEM_WORDS = 8,
    localparam int IDX_W    = $clog2(MEM_WORDS)
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wide,
    output logic                  bad,
    output logic [IDX_W-1:0]      word_idx,
    output logic [LANE_IDX_W-1:0] lane
);
    localparam int HI_W = ADDR_W + 1 - WORD_BYTE_W;

    logic [ADDR_W:0] last_byte;
    logic [HI_W-1:0] last_word;
    logic            misaligned;
    logic            beyond;

    always_comb begin
        // last byte touched by the access decides the range check
        last_byte  = {1'b0, addr} + (wide ? (ADDR_W+1)'(WORD_W/8 - 1)
                                          : (ADDR_W+1)'(LANE_W/8 - 1));
        last_word  = last_byte[ADDR_W:WORD_BYTE_W];
        misaligned = wide ? (addr[WORD_BYTE_W-1:0] != '0)
                          : (addr[LANE_BYTE_W-1:0] != '0);
        beyond     = last_word >= HI_W'(MEM_WORDS);
        bad        = misaligned | beyond;
        word_idx   = addr[WORD_BYTE_W +: IDX_W];
        lane       = addr[LANE_BYTE_W +: LANE_IDX_W];
    end
endmodule

// File: rtl/dmc_pend_queue.sv
module dmc_pend_queue
    import dmc_pkg::*;
#(
    parameter int MEM_WORDS  = 8,
    parameter int PEND_DEPTH = 2,
    localparam int IDX_W     = $clog2(MEM_WORDS),
    localparam int CNT_W     = $clog2(PEND_DEPTH + 1)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   clear,
    input  logic                                   push,
    input  logic                                   push_wide,
    input  logic [IDX_W-1:0]                       push_idx,
    input  logic [LANE_IDX_W-1:0]                  push_lane,
    input  word_t                                  push_data,
    output logic [CNT_W-1:0]                       count,
    output logic [PEND_DEPTH-1:0]                  ent_wide,
    output logic [PEND_DEPTH-1:0][IDX_W-1:0]       ent_idx,
    output logic [PEND_DEPTH-1:0][LANE_IDX_W-1:0]  ent_lane,
    output logic [PEND_DEPTH-1:0][WORD_W-1:0]      ent_data
);
    typedef struct packed {
        logic [CNT_W-1:0]                      count;
        logic [PEND_DEPTH-1:0]                 wide;
        logic [PEND_DEPTH-1:0][IDX_W-1:0]      idx;
        logic [PEND_DEPTH-1:0][LANE_IDX_W-1:0] lane;
        logic [PEND_DEPTH-1:0][WORD_W-1:0]     data;
    } queue_t;

    queue_t queue_d, queue_q;

    always_comb begin
        queue_d = queue_q;
        if (clear) begin
            queue_d.count = '0;
        end
        // a push in the clearing cycle lands in the freshly emptied buffer
        if (push && (queue_d.count < CNT_W'(PEND_DEPTH))) begin
            queue_d.wide[queue_d.count] = push_wide;
            queue_d.idx[queue_d.count]  = push_idx;
            queue_d.lane[queue_d.count] = push_lane;
            queue_d.data[queue_d.count] = push_data;
            queue_d.count               = queue_d.count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            queue_q <= '0;
        end else begin
            queue_q <= queue_d;
        end
    end

    assign count    = queue_q.count;
    assign ent_wide = queue_q.wide;
    assign ent_idx  = queue_q.idx;
    assign ent_lane = queue_q.lane;
    assign ent_data = queue_q.data;
endmodule

// File: rtl/dmc_word_store.sv
module dmc_word_store
    import dmc_pkg::*;
#(
    parameter int MEM_WORDS  = 8,
    parameter int PEND_DEPTH = 2,
    localparam int IDX_W     = $clog2(MEM_WORDS),
    localparam int CNT_W     = $clog2(PEND_DEPTH + 1)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   apply,
    input  logic [CNT_W-1:0]                       apply_cnt,
    input  logic [PEND_DEPTH-1:0]                  ent_wide,
    input  logic [PEND_DEPTH-1:0][IDX_W-1:0]       ent_idx,
    input  logic [PEND_DEPTH-1:0][LANE_IDX_W-1:0]  ent_lane,
    input  logic [PEND_DEPTH-1:0][WORD_W-1:0]      ent_data,
    input  logic [IDX_W-1:0]                       rd_idx,
    output word_t                                  rd_word
);
    typedef struct packed {
        logic [MEM_WORDS-1:0][WORD_W-1:0] words;
    } store_t;

    store_t store_d, store_q;

    always_comb begin
        store_d = store_q;
        // entries are applied oldest first so the youngest write wins
        for (int i = 0; i < PEND_DEPTH; i++) begin
            if (apply && (i < int'(apply_cnt))) begin
                if (ent_wide[i]) begin
                    store_d.words[ent_idx[i]] = ent_data[i];
                end else begin
                    store_d.words[ent_idx[i]][int'(ent_lane[i])*LANE_W +: LANE_W] =
                        ent_data[i][LANE_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    assign rd_word = store_q.words[rd_idx];
endmodule

// File: rtl/dmc_access_checker.sv
module dmc_access_checker
    import dmc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int MEM_WORDS  = 8,
    parameter int PEND_DEPTH = 2,
    localparam int CNT_W     = $clog2(PEND_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [255:0]      req_wdata,
    input  logic              txn_commit,
    input  logic              txn_abort,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [255:0]      rsp_rdata,
    output logic              fault_pending,
    output logic [CNT_W-1:0]  pend_cnt
);
    localparam int IDX_W = $clog2(MEM_WORDS);

    logic                                  bad;
    logic [IDX_W-1:0]                      word_idx;
    logic [LANE_IDX_W-1:0]                 lane;
    logic                                  apply;
    logic                                  clear;
    logic                                  push;
    word_t                                 push_data;
    word_t                                 rd_word;
    logic [CNT_W-1:0]                      q_count;
    logic [PEND_DEPTH-1:0]                 ent_wide;
    logic [PEND_DEPTH-1:0][IDX_W-1:0]      ent_idx;
    logic [PEND_DEPTH-1:0][LANE_IDX_W-1:0] ent_lane;
    logic [PEND_DEPTH-1:0][WORD_W-1:0]     ent_data;

    port_state_t st_d, st_q;

    dmc_addr_check #(
        .ADDR_W   (ADDR_W),
        .MEM_WORDS(MEM_WORDS)
    ) i_addr_check (
        .addr    (req_addr),
        .wide    (req_wide),
        .bad     (bad),
        .word_idx(word_idx),
        .lane    (lane)
    );

    dmc_pend_queue #(
        .MEM_WORDS (MEM_WORDS),
        .PEND_DEPTH(PEND_DEPTH)
    ) i_pend_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .push     (push),
        .push_wide(req_wide),
        .push_idx (word_idx),
        .push_lane(lane),
        .push_data(push_data),
        .count    (q_count),
        .ent_wide (ent_wide),
        .ent_idx  (ent_idx),
        .ent_lane (ent_lane),
        .ent_data (ent_data)
    );

    dmc_word_store #(
        .MEM_WORDS (MEM_WORDS),
        .PEND_DEPTH(PEND_DEPTH)
    ) i_word_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .apply    (apply),
        .apply_cnt(q_count),
        .ent_wide (ent_wide),
        .ent_idx  (ent_idx),
        .ent_lane (ent_lane),
        .ent_data (ent_data),
        .rd_idx   (word_idx),
        .rd_word  (rd_word)
    );

    always_comb begin
        // abort wins; a latched fault blocks the commit
        apply     = txn_commit & ~txn_abort & ~st_q.fault;
        clear     = txn_abort | apply;
        push      = req_valid & req_write & ~bad;
        push_data = req_wide ? word_t'(req_wdata)
                             : word_t'(req_wdata[LANE_W-1:0]);

        st_d           = st_q;
        st_d.rsp_valid = req_valid;
        st_d.rsp_fault = req_valid & bad;
        st_d.rdata     = '0;
        if (req_valid && !req_write && !bad) begin
            if (req_wide) begin
                st_d.rdata = rd_word;
            end else begin
                st_d.rdata = word_t'(rd_word[int'(lane)*LANE_W +: LANE_W]);
            end
        end
        if (txn_abort) begin
            st_d.fault = 1'b0;
        end
        if (req_valid && bad) begin
            st_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid     = st_q.rsp_valid;
    assign rsp_fault     = st_q.rsp_fault;
    assign rsp_rdata     = st_q.rdata;
    assign fault_pending = st_q.fault;
    assign pend_cnt      = q_count;
endmodule

// File: rtl/dmc_access_checker_sva.sv
module dmc_access_checker_sva #(
    parameter int ADDR_W     = 16,
    parameter int MEM_WORDS  = 8,
    parameter int PEND_DEPTH = 2,
    localparam int CNT_W     = $clog2(PEND_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_wide,
    input logic [ADDR_W-1:0] req_addr,
    input logic              txn_commit,
    input logic              txn_abort,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [255:0]      rsp_rdata,
    input logic              fault_pending,
    input logic [CNT_W-1:0]  pend_cnt
);
    p_wide_misalign_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_wide && (req_addr[4:0] != '0) |=> rsp_fault);

    p_wide_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_wide && (int'(req_addr >> 5) >= MEM_WORDS) |=> rsp_fault);

    p_narrow_misalign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_wide && (req_addr[1:0] != '0) |=> rsp_fault);

    p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_rdata == '0));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid && !txn_commit && !txn_abort |=> $stable(pend_cnt));

    p_abort_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        txn_abort && !req_valid |=> (pend_cnt == '0) && !fault_pending);

    p_commit_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        txn_commit |-> !fault_pending);

    p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pending && !txn_abort |=> fault_pending);

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && !txn_commit && !txn_abort &&
          (int'(pend_cnt) == PEND_DEPTH)));

    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pend_cnt) <= PEND_DEPTH);

    p_rsp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
endmodule

bind dmc_access_checker dmc_access_checker_sva #(
    .ADDR_W    (ADDR_W),
    .MEM_WORDS (MEM_WORDS),
    .PEND_DEPTH(PEND_DEPTH)
) i_dmc_sva (.*);

// File: tb/test_dmc_access_checker.sv
`timescale 1ns/1ps
module test_dmc_access_checker;
    localparam int ADDR_W = 16;
    localparam int DEPTH  = 8;
    localparam int PD     = 2;
    localparam int CNT_W  = $clog2(PD + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic              req_wide = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [255:0]      req_wdata = '0;
    logic              txn_commit = 1'b0;
    logic              txn_abort = 1'b0;
    logic              rsp_valid;
    logic              rsp_fault;
    logic [255:0]      rsp_rdata;
    logic              fault_pending;
    logic [CNT_W-1:0]  pend_cnt;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state
    logic [255:0] mm [DEPTH];
    bit           m_wide [$];
    int           m_addr [$];
    logic [255:0] m_data [$];
    bit           m_fault = 1'b0;

    always #2.5 clk = ~clk;

    dmc_access_checker #(
        .ADDR_W    (ADDR_W),
        .MEM_WORDS (DEPTH),
        .PEND_DEPTH(PD)
    ) i_dmc_access_checker (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_wide     (req_wide),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .txn_commit   (txn_commit),
        .txn_abort    (txn_abort),
        .rsp_valid    (rsp_valid),
        .rsp_fault    (rsp_fault),
        .rsp_rdata    (rsp_rdata),
        .fault_pending(fault_pending),
        .pend_cnt     (pend_cnt)
    );

    function automatic bit is_bad(bit wide, int a);
        if (wide) return (a % 32 != 0) || (a / 32 >= DEPTH);
        return (a % 4 != 0) || ((a + 3) / 32 >= DEPTH);
    endfunction

    // one clock: drive at the falling edge, compare at the next falling edge
    task automatic step(input string tag, input bit v, input bit w, input bit wide,
                        input int a, input logic [255:0] wd, input bit cm, input bit ab);
        bit           bad;
        logic [255:0] e_rd;
        bit           e_valid, e_fault, e_pend;
        int           e_cnt;
        req_valid  = v;  req_write = w; req_wide = wide;
        req_addr   = ADDR_W'(a); req_wdata = wd;
        txn_commit = cm; txn_abort = ab;
        bad     = is_bad(wide, a);
        e_rd    = '0;
        if (v && !w && !bad) begin
            if (wide) e_rd = mm[a / 32];
            else      e_rd = {224'b0, mm[a / 32][((a / 4) % 8) * 32 +: 32]};
        end
        if (ab) begin
            m_wide.delete(); m_addr.delete(); m_data.delete(); m_fault = 1'b0;
        end else if (cm && !m_fault) begin
            foreach (m_wide[k]) begin
                if (m_wide[k]) mm[m_addr[k] / 32] = m_data[k];
                else mm[m_addr[k] / 32][((m_addr[k] / 4) % 8) * 32 +: 32] = m_data[k][31:0];
            end
            m_wide.delete(); m_addr.delete(); m_data.delete();
        end
        if (v) begin
            if (bad) m_fault = 1'b1;
            else if (w) begin
                m_wide.push_back(wide); m_addr.push_back(a); m_data.push_back(wd);
            end
        end
        e_valid = v; e_fault = v && bad; e_pend = m_fault; e_cnt = m_wide.size();
        @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (rsp_valid !== e_valid || rsp_fault !== e_fault || rsp_rdata !== e_rd ||
            fault_pending !== e_pend || int'(pend_cnt) != e_cnt) begin
            n_bad++;
            $display("FAIL %s: actual v=%0b f=%0b pend=%0b cnt=%0d rd=%h expected v=%0b f=%0b pend=%0b cnt=%0d rd=%h",
                     tag, rsp_valid, rsp_fault, fault_pending, pend_cnt, rsp_rdata,
                     e_valid, e_fault, e_pend, e_cnt, e_rd);
        end
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, '0, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mm[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R11 reset outputs");
        step("R11 memory zero", 1, 0, 1, 32 * 7, '0, 0, 0);

        // wide store held until commit
        step("R7 wide store queued", 1, 1, 1, 32, {8{32'hA5A5_0001}}, 0, 0);
        step("R7 load before commit", 1, 0, 1, 32, '0, 0, 0);
        step("R7 commit", 0, 0, 0, 0, '0, 1, 0);
        step("R7 load after commit", 1, 0, 1, 32, '0, 0, 0);

        // narrow lane selection
        step("R6 narrow store lane1 word2", 1, 1, 0, 68, 256'h1234_5678, 0, 0);
        step("R6 commit", 0, 0, 0, 0, '0, 1, 0);
        step("R6 narrow load lane1", 1, 0, 0, 68, '0, 0, 0);
        step("R6 wide view of lane", 1, 0, 1, 64, '0, 0, 0);
        step("R6 narrow store top lane", 1, 1, 0, 32 + 28, {224'hFFFF, 32'hCAFE_0007}, 0, 0);
        step("R6 commit top lane", 0, 0, 0, 0, '0, 1, 0);
        step("R6 other lanes kept", 1, 0, 1, 32, '0, 0, 0);

        // issue order on commit, buffer full
        step("R10 first store", 1, 1, 0, 8, 256'h1, 0, 0);
        step("R10 second store full", 1, 1, 0, 8, 256'h2, 0, 0);
        step("R7 load same cycle as commit", 1, 0, 0, 8, '0, 1, 0);
        step("R7 later store wins", 1, 0, 0, 8, '0, 0, 0);

        // abort drops pending stores
        step("R8 store to drop", 1, 1, 1, 96, {8{32'hDEAD_BEEF}}, 0, 0);
        step("R8 abort with commit", 0, 0, 0, 0, '0, 1, 1);
        step("R8 dropped store unseen", 1, 0, 1, 96, '0, 0, 0);

        // wide rules
        step("R1 wide misaligned load", 1, 0, 1, 36, '0, 0, 0);
        step("R9 fault sticky on good access", 1, 0, 1, 32, '0, 0, 0);
        step("R9 still pending idle", 0, 0, 0, 0, '0, 0, 0);
        step("R8 abort clears fault", 0, 0, 0, 0, '0, 0, 1);
        step("R1 wide misaligned by one", 1, 0, 1, 33, '0, 0, 0);
        step("R8 abort", 0, 0, 0, 0, '0, 0, 1);
        step("R2 wide last word ok", 1, 0, 1, 32 * 7, '0, 0, 0);
        step("R2 wide beyond top", 1, 0, 1, 32 * 8, '0, 0, 0);
        step("R8 abort", 0, 0, 0, 0, '0, 0, 1);

        // narrow rules
        step("R3 narrow misaligned", 1, 0, 0, 66, '0, 0, 0);
        step("R8 abort", 0, 0, 0, 0, '0, 0, 1);
        step("R4 narrow last lane ok", 1, 0, 0, 32 * 8 - 4, '0, 0, 0);
        step("R4 narrow beyond top", 1, 0, 0, 32 * 8, '0, 0, 0);
        step("R8 abort", 0, 0, 0, 0, '0, 0, 1);

        // faulting store and load
        step("R5 good store queued", 1, 1, 0, 12, 256'h55, 0, 0);
        step("R5 faulting store not queued", 1, 1, 0, 14, 256'h66, 0, 0);
        step("R5 faulting load returns zero", 1, 0, 1, 40, '0, 0, 0);
        step("R8 abort after faults", 0, 0, 0, 0, '0, 0, 1);
        step("R5 nothing written", 1, 0, 0, 12, '0, 0, 0);

        // response per request
        step("R12 back-to-back store", 1, 1, 1, 0, {8{32'h0BAD_F00D}}, 0, 0);
        step("R12 back-to-back load", 1, 0, 1, 0, '0, 1, 0);
        step("R12 quiet cycle", 0, 0, 0, 0, '0, 0, 0);
        step("R12 load committed word", 1, 0, 1, 0, '0, 0, 0);
        idle("R12 idle");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R12 watchdog: actual still running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule